// File: doc/BRIEF.md
# Digit Blanking and Brightness Controller

This block decides, refresh slot by refresh slot, which character positions of a small multi-digit dot-matrix display may have their row drivers switched on. It merges an active-low external blank pin (which a board may toggle as a flashing or pulse-width dimming waveform) with a software master-blank bit, a per-digit "never blank me" override, and a 3-bit brightness code. The brightness code drives an internal pulse-width modulator that compares a free-running frame step count against a duty threshold. A single compatibility bit switches off the whole internal layer. When that bit is set, only the external pin counts.

The register file, row scanner and frame counter live outside. This block takes their values as plain control inputs and returns one enable per digit. The enables are registered and change only on cycles where `slot_tick` is high. No data stream passes through the block, so it has no valid/ready handshake; every pin is a plain level.

Top module: `blnk_dim_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, `digit_en` is all zeros.
- R2: With `ctl_ext_off`=0, a digit is dark whenever `frame_cnt` is at or above the duty threshold of `ctl_bright`. The thresholds out of 32 steps are, for codes 0..7: 32, 19, 13, 9, 5, 3, 2, 1.
- R3: With `ctl_ext_off`=1, every bit of `digit_en` equals `ext_blank_n`, whatever the values of `ctl_bright`, `ctl_master_blank`, `attr_hold_on` and `frame_cnt`.
- R4: With `ctl_ext_off`=0 and `attr_hold_on[n]`=0, digit n is dark when `ext_blank_n`=0 or `ctl_master_blank`=1. Otherwise it is lit inside the duty window.
- R5: With `ctl_ext_off`=0 and `attr_hold_on[n]`=1, digit n is lit inside the duty window, whatever the values of `ext_blank_n` and `ctl_master_blank`.
- R6: `digit_en` takes the value computed from the inputs sampled at a clock edge where `slot_tick`=1. It holds its value across edges where `slot_tick`=0.
- R7: Code 0 is full duty. With `ctl_ext_off`=0 and `ctl_bright`=0, no value of `frame_cnt` darkens a digit that is not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_tick | input | 1 | Refresh-slot strobe; enables update when high |
| frame_cnt | input | PWM_BITS | Free-running duty step count (0..31 by default) |
| ext_blank_n | input | 1 | External blank, 0 = blank |
| ctl_master_blank | input | 1 | Software blank of all digits not held on |
| ctl_ext_off | input | 1 | 1 = ignore brightness, master blank and hold-on bits |
| ctl_bright | input | 3 | Brightness code, 0 = brightest |
| attr_hold_on | input | NUM_DIGITS | Per-digit blank override, 1 = never blanked |
| digit_en | output | NUM_DIGITS | Per-digit row-driver enable |

## Verification
The hardest case to reach is a masked override. Here `ctl_ext_off` must hide a set hold-on bit, while an asserted master blank and a dim code at a frame step just past its threshold would each give a different answer. Each of these cases matters only for a narrow range of frame steps. The stimulus therefore sweeps every combination of the compatibility bit, master blank, external blank, all 16 hold-on patterns, all 8 codes and all 32 frame steps. Every threshold edge and every masking case is then met at least once.

// File: rtl/blnk_dim_pkg.sv
package blnk_dim_pkg;

  localparam int unsigned CODE_W = 3;

  // Duty level in percent for each brightness code (0 = brightest).
  function automatic int unsigned duty_pct(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 100;
      3'd1:    return 60;
      3'd2:    return 40;
      3'd3:    return 27;
      3'd4:    return 17;
      3'd5:    return 10;
      3'd6:    return 7;
      default: return 3;
    endcase
  endfunction

  // Number of lit steps out of 'steps', rounded to nearest, never zero.
  function automatic int unsigned duty_steps(input logic [CODE_W-1:0] code,
                                             input int unsigned steps);
    int unsigned n;
    n = (duty_pct(code) * steps + 50) / 100;
    if (n == 0) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/blnk_pwm_gate.sv
module blnk_pwm_gate
  import blnk_dim_pkg::*;
#(
  parameter int unsigned PWM_BITS = 5
) (
  input  logic [PWM_BITS-1:0] frame_cnt,
  input  logic [CODE_W-1:0]   bright,
  input  logic                ext_off,
  output logic                pwm_on
);
  localparam int unsigned STEPS = 1 << PWM_BITS;
  localparam int unsigned TW    = PWM_BITS + 1;

  logic [TW-1:0] thresh;
  logic          in_window;

  always_comb begin
    thresh    = TW'(duty_steps(bright, STEPS));
    in_window = ({1'b0, frame_cnt} < thresh);
    // Internal dimming exists only while the extended layer is active.
    pwm_on    = ext_off | in_window;
  end
endmodule

// File: rtl/blnk_digit_gate.sv
module blnk_digit_gate (
  input  logic ext_blank_n,
  input  logic master_blank,
  input  logic hold_on,
  input  logic ext_off,
  output logic lit
);
  logic any_blank;

  always_comb begin
    any_blank = ~ext_blank_n | master_blank;
    if (ext_off) lit = ext_blank_n;
    else         lit = hold_on | ~any_blank;
  end
endmodule

// File: rtl/blnk_dim_ctrl.sv
module blnk_dim_ctrl
  import blnk_dim_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned PWM_BITS   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_tick,
  input  logic [PWM_BITS-1:0]   frame_cnt,
  input  logic                  ext_blank_n,
  input  logic                  ctl_master_blank,
  input  logic                  ctl_ext_off,
  input  logic [CODE_W-1:0]     ctl_bright,
  input  logic [NUM_DIGITS-1:0] attr_hold_on,
  output logic [NUM_DIGITS-1:0] digit_en
);
  logic                  pwm_on;
  logic [NUM_DIGITS-1:0] lit;
  logic [NUM_DIGITS-1:0] en_next;

  blnk_pwm_gate #(.PWM_BITS(PWM_BITS)) pwm_i (
    .frame_cnt (frame_cnt),
    .bright    (ctl_bright),
    .ext_off   (ctl_ext_off),
    .pwm_on    (pwm_on)
  );

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    blnk_digit_gate gate_i (
      .ext_blank_n  (ext_blank_n),
      .master_blank (ctl_master_blank),
      .hold_on      (attr_hold_on[g]),
      .ext_off      (ctl_ext_off),
      .lit          (lit[g])
    );
    assign en_next[g] = pwm_on & lit[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         digit_en <= '0;
    else if (slot_tick) digit_en <= en_next;
  end
endmodule

// File: rtl/blnk_dim_ctrl_chk.sv
module blnk_dim_ctrl_chk
  import blnk_dim_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned PWM_BITS   = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  slot_tick,
  input logic [PWM_BITS-1:0]   frame_cnt,
  input logic                  ext_blank_n,
  input logic                  ctl_master_blank,
  input logic                  ctl_ext_off,
  input logic [CODE_W-1:0]     ctl_bright,
  input logic [NUM_DIGITS-1:0] attr_hold_on,
  input logic [NUM_DIGITS-1:0] digit_en
);
  localparam int unsigned STEPS = 1 << PWM_BITS;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(digit_en)); // R6

  AST_EXT_OFF_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && ctl_ext_off) |=> (digit_en == {NUM_DIGITS{$past(ext_blank_n)}})); // R3

  AST_MASTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !ctl_ext_off && ctl_master_blank)
      |=> ((digit_en & ~$past(attr_hold_on)) == '0)); // R4

  AST_HOLD_ON_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !ctl_ext_off && ctl_bright == '0)
      |=> ((digit_en & $past(attr_hold_on)) == $past(attr_hold_on))); // R5

  AST_DIM_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !ctl_ext_off && (int'(frame_cnt) >= duty_steps(ctl_bright, STEPS)))
      |=> (digit_en == '0)); // R2
endmodule

bind blnk_dim_ctrl blnk_dim_ctrl_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .PWM_BITS   (PWM_BITS)
) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .slot_tick        (slot_tick),
  .frame_cnt        (frame_cnt),
  .ext_blank_n      (ext_blank_n),
  .ctl_master_blank (ctl_master_blank),
  .ctl_ext_off      (ctl_ext_off),
  .ctl_bright       (ctl_bright),
  .attr_hold_on     (attr_hold_on),
  .digit_en         (digit_en)
);

// File: tb/blnk_dim_ctrl_tb_top.sv
module blnk_dim_ctrl_tb_top;
  localparam int ND = 4;
  localparam int PB = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_tick = 1'b0;
  logic [PB-1:0] frame_cnt = '0;
  logic          ext_blank_n = 1'b1;
  logic          ctl_master_blank = 1'b0;
  logic          ctl_ext_off = 1'b0;
  logic [2:0]    ctl_bright = '0;
  logic [ND-1:0] attr_hold_on = '0;
  logic [ND-1:0] digit_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blnk_dim_ctrl #(.NUM_DIGITS(ND), .PWM_BITS(PB)) dut_i (
    .clk (clk), .rst_n (rst_n), .slot_tick (slot_tick),
    .frame_cnt (frame_cnt), .ext_blank_n (ext_blank_n),
    .ctl_master_blank (ctl_master_blank), .ctl_ext_off (ctl_ext_off),
    .ctl_bright (ctl_bright), .attr_hold_on (attr_hold_on),
    .digit_en (digit_en)
  );

  function automatic int lit_steps(input int code);
    case (code)
      0: return 32; 1: return 19; 2: return 13; 3: return 9;
      4: return 5;  5: return 3;  6: return 2;  default: return 1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [ND-1:0] act, input logic [ND-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #200000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ND-1:0] exp;
    logic [ND-1:0] held;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", digit_en, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", digit_en, '0);

    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < 2; b++)
          for (int h = 0; h < 16; h++)
            for (int c = 0; c < 8; c++)
              for (int f = 0; f < 32; f++) begin
                ctl_ext_off = e[0]; ctl_master_blank = m[0]; ext_blank_n = b[0];
                attr_hold_on = h[ND-1:0]; ctl_bright = c[2:0]; frame_cnt = f[PB-1:0];
                slot_tick = 1'b1;
                if (e == 1) begin
                  exp = {ND{b[0]}}; tag = "R3";
                end else if (f >= lit_steps(c)) begin
                  exp = '0; tag = "R2";
                end else begin
                  for (int d = 0; d < ND; d++)
                    exp[d] = h[d] | (b[0] & ~m[0]);
                  if (c == 0) tag = "R7";
                  else if (h != 0) tag = "R5";
                  else tag = "R4";
                end
                @(posedge clk);
                @(negedge clk);
                check(tag, digit_en, exp);
              end

    // R6: without a tick, changed inputs leave the enables untouched.
    ctl_ext_off = 1'b1; ext_blank_n = 1'b1; slot_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", digit_en, '1);
    held = digit_en;
    slot_tick = 1'b0; ext_blank_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      frame_cnt = PB'(k);
      @(posedge clk); @(negedge clk);
      check("R6", digit_en, held);
    end
    slot_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", digit_en, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule